// File: doc/BRIEF.md
# Wheel-Speed Input Channel Self-Test Controller

This block checks the wheel-speed capture paths of a braking controller once after every reset. While the check runs it keeps its gate control low, so the live wheel-speed inputs cannot reach the processor. It drives a generated 100 Hz square wave with 50% duty on all four capture outputs instead. The processor measures that wave on its capture inputs and answers with a pass or a fail strobe.

On a pass the gate control goes high, and from then on each conditioned wheel-speed input is forwarded to its own capture output. On a fail strobe, or if no answer arrives within the timeout window, the block locks into a fail state. It stays there with the gate low and the capture outputs quiet until the next reset. A timeout also raises a sticky flag, so software can tell a silent processor apart from a reported mismatch. The current phase can be read on a two-bit status output.

The system clock rate, the reference frequency, the timeout in milliseconds and the channel count are all parameters. The clock rate must be a whole multiple of twice the reference frequency and a whole multiple of 1000.

Top module: `chan_selftest_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle it is sampled, the gate control is 0, the status is 00, every capture output is 0 and the timeout flag is 0.
- R2: The gate control is 1 only while the status reads PASS (10). It stays 0 throughout the test and fail phases.
- R3: During the test phase the reference wave on each capture output stays high for exactly CLK_HZ/(2*REF_HZ) clock cycles, then low for the same count, and repeats with no drift.
- R4: Any window of CLK_HZ/10 consecutive test-phase cycles holds exactly 10 rising edges of the reference (100 Hz at default settings).
- R5: Until the gate control has risen, all capture outputs carry the same value on every cycle: all 0 or all 1.
- R6: A pass strobe sampled in the test phase moves the status to PASS (10) and the gate control to 1 on that edge. From then on, each capture output equals its wheel-speed input from the previous clock edge.
- R7: A fail strobe sampled in the test phase moves the status to FAIL (11). That state holds until reset, with the gate at 0, the capture outputs at 0 and the timeout flag left at 0. Later pass strobes are ignored.
- R8: When pass and fail are sampled on the same edge in the test phase, the fail wins.
- R9: If neither strobe arrives, the test phase lasts exactly (CLK_HZ/1000)*TIMEOUT_MS cycles. The block then enters FAIL with the timeout flag at 1.
- R10: The status encoding is RESET=00, TEST=01, PASS=10, FAIL=11. The block leaves RESET for TEST on the first clock edge with reset low.
- R11: Pass and fail strobes outside the test phase are ignored. In PASS, a fail strobe leaves the status at PASS and forwarding unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| whl_in | input | NUM_CH | Conditioned wheel-speed inputs, one per wheel |
| tst_pass | input | 1 | Pass strobe from the processor |
| tst_fail | input | 1 | Fail strobe from the processor |
| gate_en | output | 1 | Gate control; 1 lets wheel inputs through |
| cap_out | output | NUM_CH | Capture outputs toward the processor |
| status | output | 2 | Current phase: 00 reset, 01 test, 10 pass, 11 fail |
| tmo_flag | output | 1 | Sticky flag; set when the test timed out |

## Verification
The bench measures the high and low run lengths of the reference and counts rising edges over an exact window. An off-by-one half-period counter would show up there as a 9- or 11-cycle run, or as the wrong number of pulses. It fires pass and fail on the same edge, where a design that checks pass first would open the gate after a failed test. It sends strobes after the test has ended, where a design with a non-sticky fail or pass would change state. It also counts the length of the unanswered test phase, where a timeout counter that is one cycle off would end the test a cycle early or late, or leave the flag clear.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'b00,
    ST_TEST  = 2'b01,
    ST_PASS  = 2'b10,
    ST_FAIL  = 2'b11
  } stc_state_e;
endpackage

// File: rtl/stc_ref_gen.sv
module stc_ref_gen #(
  parameter int HALF_CYC = 5000,
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic wave
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (cnt == CW'(HALF_CYC - 1)) begin
      cnt  <= '0;
      wave <= ~wave;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: the wave only changes level after a full half period has been counted
  p_half_period_r3: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$past(rst) && (wave != $past(wave)))
      |-> ($past(cnt) == CW'(HALF_CYC - 1)));
endmodule

// File: rtl/stc_seq.sv
module stc_seq
  import stc_pkg::*;
#(
  parameter int TMO_CYC = 1000000,
  localparam int TW = $clog2(TMO_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pass_i,
  input  logic       fail_i,
  output stc_state_e state_o,
  output logic       gate_o,
  output logic       tmo_o
);
  stc_state_e    state_q, nxt;
  logic [TW-1:0] tcnt;
  logic          gate_q, tmo_q, hit, tmo_set;

  assign hit = (tcnt == TW'(TMO_CYC - 1));

  always_comb begin
    nxt     = state_q;
    tmo_set = 1'b0;
    case (state_q)
      ST_RESET: nxt = ST_TEST;
      ST_TEST: begin
        if (fail_i)      nxt = ST_FAIL;
        else if (pass_i) nxt = ST_PASS;
        else if (hit) begin
          nxt     = ST_FAIL;
          tmo_set = 1'b1;
        end
      end
      default: nxt = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RESET;
      tcnt    <= '0;
      gate_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      gate_q  <= (nxt == ST_PASS);
      tmo_q   <= tmo_q | tmo_set;
      tcnt    <= (state_q == ST_TEST) ? tcnt + 1'b1 : '0;
    end
  end

  assign state_o = state_q;
  assign gate_o  = gate_q;
  assign tmo_o   = tmo_q;

  // R2: the gate is open only in PASS
  p_gate_in_pass_r2: assert property (@(posedge clk) disable iff (rst)
    gate_q |-> (state_q == ST_PASS));
  // R7: fail is sticky until reset
  p_fail_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FAIL) |=> (state_q == ST_FAIL));
  // R11: pass is sticky, later strobes ignored
  p_pass_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PASS) |=> (state_q == ST_PASS));
  // R8: a fail strobe in TEST always wins
  p_fail_prio_r8: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_TEST) && fail_i) |=> (state_q == ST_FAIL && !tmo_q));
  // R9: the timeout flag implies the fail state
  p_tmo_fail_r9: assert property (@(posedge clk) disable iff (rst)
    tmo_q |-> (state_q == ST_FAIL));
  // R10: reset phase lasts one edge
  p_reset_leave_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RESET) |=> (state_q == ST_TEST));
endmodule

// File: rtl/stc_route.sv
module stc_route #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate,
  input  logic              ref_en,
  input  logic              ref_wave,
  input  logic [NUM_CH-1:0] whl,
  output logic [NUM_CH-1:0] cap
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) cap[i] <= 1'b0;
      else     cap[i] <= gate ? whl[i] : (ref_en & ref_wave);
    end
  end

  // R6: once the gate is open the outputs follow the inputs one edge later
  p_forward_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(gate) && !$past(rst)) |-> (cap == $past(whl)));
endmodule

// File: rtl/chan_selftest_ctrl.sv
module chan_selftest_ctrl
  import stc_pkg::*;
#(
  parameter int CLK_HZ     = 1000000,
  parameter int REF_HZ     = 100,
  parameter int TIMEOUT_MS = 1000,
  parameter int NUM_CH     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] whl_in,
  input  logic              tst_pass,
  input  logic              tst_fail,
  output logic              gate_en,
  output logic [NUM_CH-1:0] cap_out,
  output logic [1:0]        status,
  output logic              tmo_flag
);
  localparam int HALF_CYC = CLK_HZ / (2 * REF_HZ);
  localparam int TMO_CYC  = (CLK_HZ / 1000) * TIMEOUT_MS;

  stc_state_e st;
  logic       ref_en, ref_wave;

  stc_seq #(.TMO_CYC(TMO_CYC)) u_seq (
    .clk(clk), .rst(rst), .pass_i(tst_pass), .fail_i(tst_fail),
    .state_o(st), .gate_o(gate_en), .tmo_o(tmo_flag)
  );

  assign ref_en = (st == ST_TEST);

  stc_ref_gen #(.HALF_CYC(HALF_CYC)) u_ref (
    .clk(clk), .rst(rst), .en(ref_en), .wave(ref_wave)
  );

  stc_route #(.NUM_CH(NUM_CH)) u_route (
    .clk(clk), .rst(rst), .gate(gate_en), .ref_en(ref_en),
    .ref_wave(ref_wave), .whl(whl_in), .cap(cap_out)
  );

  assign status = st;

  // R5: before the gate opens every channel carries the same value
  p_common_ref_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(gate_en) |-> (cap_out == '0 || cap_out == '1));
  // R7: a settled fail state keeps the outputs quiet
  p_fail_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b11 && $past(status) == 2'b11 && !$past(rst))
      |-> (cap_out == '0 && !gate_en));
endmodule

// File: tb/chan_selftest_ctrl_tb_top.sv
module chan_selftest_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 2000;
  localparam int REF_HZ     = 100;
  localparam int TIMEOUT_MS = 1000;
  localparam int NCH        = 4;
  localparam int HALF       = CLK_HZ / (2 * REF_HZ);
  localparam int TMO        = (CLK_HZ / 1000) * TIMEOUT_MS;
  localparam int WIN        = CLK_HZ / 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] whl = '0;
  logic           pass_s = 1'b0, fail_s = 1'b0;
  logic           gate_en, tmo_flag;
  logic [NCH-1:0] cap_out;
  logic [1:0]     status;

  int n_chk = 0, n_fail = 0, cyc = 0, eq_bad = 0;
  bit eq_en = 1'b0, done = 1'b0;

  typedef struct { logic [NCH-1:0] val; int stamp; } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  chan_selftest_ctrl #(.CLK_HZ(CLK_HZ), .REF_HZ(REF_HZ),
    .TIMEOUT_MS(TIMEOUT_MS), .NUM_CH(NCH)) dut_i (
    .clk(clk), .rst(rst), .whl_in(whl), .tst_pass(pass_s), .tst_fail(fail_s),
    .gate_en(gate_en), .cap_out(cap_out), .status(status), .tmo_flag(tmo_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares forwarded values one edge after they were driven
  always @(negedge clk) begin
    if (sb_q.size() > 0 && sb_q[0].stamp < cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      check(cap_out == e.val, "R6 forward", int'(cap_out), int'(e.val));
    end
    if (eq_en && cap_out != '0 && cap_out != '1) eq_bad++;
  end

  task automatic drive_whl(input logic [NCH-1:0] v);
    exp_t e;
    @(negedge clk);
    whl = v;
    e.val = v;
    e.stamp = cyc;
    sb_q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pass_s = 1'b0; fail_s = 1'b0; whl = '0;
    repeat (4) @(negedge clk);
    check(status == 2'b00 && !gate_en && cap_out == '0 && !tmo_flag,
          "R1 reset state", int'(status), 0);
    rst = 1'b0;
  endtask

  task automatic pulse(input bit p, input bit f);
    @(negedge clk);
    pass_s = p; fail_s = f;
    @(negedge clk);
    pass_s = 1'b0; fail_s = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    int hi, lo, rises;
    logic prev;
    // ---- scenario A: reference measurement then pass
    do_reset();
    @(negedge clk);
    check(status == 2'b01, "R10 enters TEST", int'(status), 1);
    eq_en = 1'b1;
    prev = cap_out[0];
    while (!(cap_out[0] && !prev)) begin prev = cap_out[0]; @(negedge clk); end
    for (int k = 0; k < 2; k++) begin
      hi = 1;
      @(negedge clk);
      while (cap_out[0]) begin hi++; @(negedge clk); end
      check(hi == HALF, "R3 high run", hi, HALF);
      lo = 1;
      @(negedge clk);
      while (!cap_out[0]) begin lo++; @(negedge clk); end
      check(lo == HALF, "R3 low run", lo, HALF);
    end
    rises = 0;
    prev = cap_out[0];
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      if (cap_out[0] && !prev) rises++;
      prev = cap_out[0];
    end
    check(rises == 10, "R4 pulses per window", rises, 10);
    check(!gate_en, "R2 gate low in TEST", int'(gate_en), 0);
    pulse(1'b1, 1'b0);
    check(status == 2'b10 && gate_en, "R6 pass opens gate", int'(status), 2);
    eq_en = 1'b0;
    check(eq_bad == 0, "R5 common reference", eq_bad, 0);
    drive_whl(4'b0001); drive_whl(4'b1010); drive_whl(4'b0110);
    drive_whl(4'b1111); drive_whl(4'b0000); drive_whl(4'b1001);
    repeat (2) @(negedge clk);
    pulse(1'b0, 1'b1);
    check(status == 2'b10 && gate_en, "R11 fail ignored in PASS", int'(status), 2);
    drive_whl(4'b0101);
    repeat (2) @(negedge clk);
    check(sb_q.size() == 0, "R6 scoreboard drained", sb_q.size(), 0);

    // ---- scenario B: fail strobe
    do_reset();
    pulse(1'b0, 1'b1);
    check(status == 2'b11 && !gate_en && !tmo_flag, "R7 fail latched", int'(status), 3);
    pulse(1'b1, 1'b0);
    @(negedge clk);
    whl = '1;
    repeat (2) @(negedge clk);
    check(status == 2'b11, "R7 pass after fail ignored", int'(status), 3);
    check(cap_out == '0 && !gate_en, "R7 outputs quiet", int'(cap_out), 0);

    // ---- scenario C: both strobes together
    do_reset();
    pulse(1'b1, 1'b1);
    check(status == 2'b11 && !gate_en, "R8 fail wins", int'(status), 3);

    // ---- scenario D: timeout
    do_reset();
    begin
      int tcount = 0, gbad = 0;
      @(negedge clk);
      while (status == 2'b01) begin
        tcount++;
        if (gate_en) gbad++;
        @(negedge clk);
      end
      check(tcount == TMO, "R9 timeout length", tcount, TMO);
      check(gbad == 0, "R2 gate low through test", gbad, 0);
    end
    check(status == 2'b11 && tmo_flag, "R9 timeout fail flag", int'(tmo_flag), 1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    finish_run();
  end
endmodule